// File: doc/BRIEF.md
# Two-Stage Scheduled Output Event Generator

This block drives one output pin to a programmed level at a programmed raw time. Raw time is a free-running two-word counter kept inside the block. The fast low word advances on every clock. The slow high word advances each time the low word wraps. The time of the event is given as a high part and a low part in the same units.

A full-width comparison is not used. The high part of the target is checked against the high word only at the cycle where the low word reads zero, and once at the moment of arming. Only after that check succeeds is a narrow equality compare on the low word allowed to fire. Until then, a low-word match has no effect.

Software loads the target, the pin level and an arm pulse, then waits for the done flag. A target that has already passed raises an error flag instead of driving the pin. Arming a chain of events with alternating levels builds a pulse train.

Top module: `evg_sched_out`

## Requirements
- R1: After reset, pin_o, busy_o, done_o and err_o are 0, and raw_hi_o and raw_lo_o are 0.
- R2: raw_lo_o increases by one every cycle and wraps from all ones to 0. raw_hi_o increases by one exactly on the cycle in which raw_lo_o becomes 0, and holds otherwise.
- R3: An arm pulse accepted in idle with a target later than the current raw time sets busy_o in the following cycle. pin_o keeps its value until the event fires.
- R4: While the high part of the target has not yet matched, raw_lo_o equalling the low part of the target leaves pin_o and busy_o unchanged.
- R5: The high part is compared only at the cycle where raw_lo_o is 0. After it matches, the event fires at the next cycle where raw_lo_o equals the low part of the target. A low part of 0 fires on that same zero cycle.
- R6: If, at arming, the high part of the target equals raw_hi_o and the low part is greater than raw_lo_o, the event fires within the current wrap period without waiting for a wrap.
- R7: The event fires at the clock edge that ends the cycle in which (raw_hi_o, raw_lo_o) equals the target. At that edge pin_o takes the programmed level, done_o becomes 1 and busy_o becomes 0.
- R8: A target at or before the raw time seen at arming sets err_o in the next cycle. In that case busy_o stays 0 and pin_o is not changed. "At or before" means the high part is smaller, or the high part is equal and the low part is not greater.
- R9: clr_i clears done_o and err_o in the next cycle. An accepted arm pulse also clears both flags.
- R10: An arm pulse while busy_o is 1 is ignored. The pending target and level stay as first armed.
- R11: Successive armed events with alternating levels produce a pulse train, with each edge at its own programmed raw time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | One-cycle arm command |
| tgt_hi_i | input | HI_W | High part of the target raw time |
| tgt_lo_i | input | LO_W | Low part of the target raw time |
| level_i | input | 1 | Level to drive on pin_o when the event fires |
| clr_i | input | 1 | Clears done and error flags |
| raw_hi_o | output | HI_W | Raw time high word |
| raw_lo_o | output | LO_W | Raw time low word |
| pin_o | output | 1 | Scheduled output pin |
| busy_o | output | 1 | An event is pending |
| done_o | output | 1 | Last armed event has fired |
| err_o | output | 1 | Last arm request named a past target |

## Verification
Every result appears one clock edge after its cause. busy_o and err_o follow one edge after the arm pulse is sampled. pin_o and done_o change one edge after the cycle in which the raw time equals the target. Flag clearing follows one edge after clr_i. The bench drives and samples on the falling edge. It waits until the raw time it reads equals the target, confirms that pin_o has not yet moved, and then checks the new values at the next falling edge. Low-word matches that fall before the high part has matched are sampled the same way, and there the pin must be unchanged.

// File: rtl/evg_pkg.sv
package evg_pkg;
  typedef enum logic [1:0] {
    EVG_IDLE    = 2'd0,
    EVG_WAIT_HI = 2'd1,
    EVG_WAIT_LO = 2'd2
  } evg_state_e;
endpackage

// File: rtl/evg_rawtime.sv
module evg_rawtime #(
  parameter int HI_W = 16,
  parameter int LO_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [HI_W-1:0] hi_o,
  output logic [LO_W-1:0] lo_o,
  output logic            zero_pass_o
);
  localparam logic [LO_W-1:0] LO_MAX = {LO_W{1'b1}};

  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      lo_q <= lo_q + 1'b1;
      if (lo_q == LO_MAX) hi_q <= hi_q + 1'b1;
    end
  end

  assign hi_o        = hi_q;
  assign lo_o        = lo_q;
  assign zero_pass_o = (lo_q == '0);

  AST_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_q != '0) |-> $stable(hi_q)); // R2
endmodule

// File: rtl/evg_hi_gate.sv
module evg_hi_gate #(
  parameter int HI_W = 16
) (
  input  logic            wait_hi_i,
  input  logic            wait_lo_i,
  input  logic            zero_pass_i,
  input  logic [HI_W-1:0] hi_now_i,
  input  logic [HI_W-1:0] tgt_hi_i,
  output logic            upper_ok_o,
  output logic            open_o
);
  // Slow stage: the upper word is examined only when the low word reads zero.
  assign upper_ok_o = wait_hi_i && zero_pass_i && (hi_now_i == tgt_hi_i);
  assign open_o     = wait_lo_i || upper_ok_o;
endmodule

// File: rtl/evg_lo_coinc.sv
module evg_lo_coinc #(
  parameter int LO_W = 6
) (
  input  logic            open_i,
  input  logic [LO_W-1:0] lo_now_i,
  input  logic [LO_W-1:0] tgt_lo_i,
  output logic            coinc_o,
  output logic            fire_o
);
  assign coinc_o = (lo_now_i == tgt_lo_i);
  assign fire_o  = open_i && coinc_o;
endmodule

// File: rtl/evg_sched_out.sv
module evg_sched_out
  import evg_pkg::*;
#(
  parameter int HI_W = 16,
  parameter int LO_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  input  logic [HI_W-1:0] tgt_hi_i,
  input  logic [LO_W-1:0] tgt_lo_i,
  input  logic            level_i,
  input  logic            clr_i,
  output logic [HI_W-1:0] raw_hi_o,
  output logic [LO_W-1:0] raw_lo_o,
  output logic            pin_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o
);
  function automatic logic target_late(input logic [HI_W-1:0] t_hi, input logic [LO_W-1:0] t_lo,
                                       input logic [HI_W-1:0] n_hi, input logic [LO_W-1:0] n_lo);
    return (t_hi < n_hi) || ((t_hi == n_hi) && (t_lo <= n_lo));
  endfunction

  function automatic logic target_this_period(input logic [HI_W-1:0] t_hi,
                                              input logic [HI_W-1:0] n_hi);
    return t_hi == n_hi;
  endfunction

  evg_state_e      state_q;
  logic [HI_W-1:0] tgt_hi_q;
  logic [LO_W-1:0] tgt_lo_q;
  logic            lvl_q, pin_q, done_q, err_q;

  logic [HI_W-1:0] raw_hi;
  logic [LO_W-1:0] raw_lo;
  logic            zero_pass, upper_ok, stage_open, lo_coinc, fire;
  logic            arm_accept, arm_late, arm_here;

  evg_rawtime #(.HI_W(HI_W), .LO_W(LO_W)) u_raw (
    .clk_i(clk_i), .rst_ni(rst_ni), .hi_o(raw_hi), .lo_o(raw_lo), .zero_pass_o(zero_pass)
  );

  evg_hi_gate #(.HI_W(HI_W)) u_hi (
    .wait_hi_i(state_q == EVG_WAIT_HI), .wait_lo_i(state_q == EVG_WAIT_LO),
    .zero_pass_i(zero_pass), .hi_now_i(raw_hi), .tgt_hi_i(tgt_hi_q),
    .upper_ok_o(upper_ok), .open_o(stage_open)
  );

  evg_lo_coinc #(.LO_W(LO_W)) u_lo (
    .open_i(stage_open), .lo_now_i(raw_lo), .tgt_lo_i(tgt_lo_q),
    .coinc_o(lo_coinc), .fire_o(fire)
  );

  assign arm_accept = arm_i && (state_q == EVG_IDLE);
  assign arm_late   = target_late(tgt_hi_i, tgt_lo_i, raw_hi, raw_lo);
  assign arm_here   = target_this_period(tgt_hi_i, raw_hi);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q  <= EVG_IDLE;
      tgt_hi_q <= '0;
      tgt_lo_q <= '0;
      lvl_q    <= 1'b0;
      pin_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (clr_i) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      unique case (state_q)
        EVG_IDLE: begin
          if (arm_accept) begin
            tgt_hi_q <= tgt_hi_i;
            tgt_lo_q <= tgt_lo_i;
            lvl_q    <= level_i;
            done_q   <= 1'b0;
            err_q    <= arm_late;
            if (!arm_late) state_q <= arm_here ? EVG_WAIT_LO : EVG_WAIT_HI;
          end
        end
        EVG_WAIT_HI, EVG_WAIT_LO: begin
          if (fire) begin
            pin_q   <= lvl_q;
            done_q  <= 1'b1;
            state_q <= EVG_IDLE;
          end else if (upper_ok) begin
            state_q <= EVG_WAIT_LO;
          end
        end
        default: state_q <= EVG_IDLE;
      endcase
    end
  end

  assign raw_hi_o = raw_hi;
  assign raw_lo_o = raw_lo;
  assign pin_o    = pin_q;
  assign busy_o   = (state_q != EVG_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;

  AST_ARM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_accept && !arm_late) |=> busy_o && $stable(pin_o)); // R3
  AST_LOW_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == EVG_WAIT_HI && lo_coinc && !upper_ok) |=> $stable(pin_o) && busy_o); // R4
  AST_FIRE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> done_o && !busy_o); // R7
  AST_LATE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_accept && arm_late) |=> err_o && !busy_o && $stable(pin_o)); // R8
  AST_CLR_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !arm_accept && !fire) |=> !done_o && !err_o); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && arm_i && !fire) |=> $stable(tgt_hi_q) && $stable(tgt_lo_q) && $stable(lvl_q)); // R10
endmodule

// File: tb/evg_sched_out_tb.sv
module evg_sched_out_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HI_W = 16;
  localparam int LO_W = 6;
  localparam int LO_MAX = (1 << LO_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 1'b0, lvl = 1'b0, clr = 1'b0;
  logic [HI_W-1:0] thi = '0;
  logic [LO_W-1:0] tlo = '0;
  logic [HI_W-1:0] rhi;
  logic [LO_W-1:0] rlo;
  logic pin, busy, done, err;
  int checks = 0, errors = 0;
  logic exp_pin = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evg_sched_out #(.HI_W(HI_W), .LO_W(LO_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .tgt_hi_i(thi), .tgt_lo_i(tlo),
    .level_i(lvl), .clr_i(clr), .raw_hi_o(rhi), .raw_lo_o(rlo),
    .pin_o(pin), .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_raw(input int th, input int tl);
    int n = 0;
    while (!(int'(rhi) == th && int'(rlo) == tl) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("raw time reached", n < 5000 ? 1 : 0, 1);
  endtask

  task automatic do_arm(input int th, input int tl, input logic l);
    arm = 1'b1; thi = HI_W'(th); tlo = LO_W'(tl); lvl = l;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic fire_check(input string req, input int th, input int tl, input logic l);
    wait_raw(th, tl);
    chk({req, " pin before edge"}, int'(pin), int'(exp_pin));
    @(negedge clk);
    exp_pin = l;
    chk({req, " pin level"}, int'(pin), int'(l));
    chk({req, " done"}, int'(done), 1);
    chk({req, " busy"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    chk("R1 pin", int'(pin), 0);   chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0); chk("R1 err", int'(err), 0);
    chk("R1 raw", int'(rhi) + int'(rlo), 0);
  endtask

  task automatic t_counter();
    int h = int'(rhi), l = int'(rlo);
    @(negedge clk);
    chk("R2 lo step", int'(rlo), (l + 1) & LO_MAX);
    wait_raw(h, LO_MAX);
    @(negedge clk);
    chk("R2 lo wrap", int'(rlo), 0);
    chk("R2 hi step", int'(rhi), h + 1);
    @(negedge clk);
    chk("R2 hi hold", int'(rhi), h + 1);
  endtask

  task automatic t_future();
    int h = int'(rhi);
    do_arm(h + 2, 5, 1'b1);
    chk("R3 busy", int'(busy), 1);
    chk("R3 pin held", int'(pin), int'(exp_pin));
    wait_raw(h + 1, 5);
    @(negedge clk);
    chk("R4 early low match pin", int'(pin), int'(exp_pin));
    chk("R4 early low match busy", int'(busy), 1);
    fire_check("R5 R7 future", h + 2, 5, 1'b1);
  endtask

  task automatic t_clear();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R9 done cleared", int'(done), 0);
  endtask

  task automatic t_zero_low();
    int h = int'(rhi);
    do_arm(h + 1, 0, 1'b0);
    fire_check("R5 low zero", h + 1, 0, 1'b0);
  endtask

  task automatic t_current();
    int h, l;
    if (int'(rlo) > 40) wait_raw(int'(rhi) + 1, 2);
    h = int'(rhi); l = int'(rlo);
    do_arm(h, l + 10, 1'b1);
    chk("R6 busy", int'(busy), 1);
    fire_check("R6 current period", h, l + 10, 1'b1);
    chk("R6 no wrap", int'(rhi), h);
  endtask

  task automatic t_busy_ignore();
    int h = int'(rhi);
    do_arm(h + 1, 20, 1'b0);
    do_arm(h + 1, 10, 1'b1);
    wait_raw(h + 1, 10);
    @(negedge clk);
    chk("R10 second arm ignored pin", int'(pin), int'(exp_pin));
    chk("R10 still busy", int'(busy), 1);
    fire_check("R10 first target kept", h + 1, 20, 1'b0);
  endtask

  task automatic t_late();
    int h = int'(rhi), l = int'(rlo);
    do_arm(h - 1, 30, 1'b1);
    chk("R8 err older hi", int'(err), 1);
    chk("R8 busy", int'(busy), 0);
    chk("R9 arm clears done", int'(done), 0);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R9 err cleared", int'(err), 0);
    if (int'(rlo) == 0) @(negedge clk);
    h = int'(rhi); l = int'(rlo);
    do_arm(h, l, 1'b1);
    chk("R8 err equal time", int'(err), 1);
    repeat (70) @(negedge clk);
    chk("R8 pin untouched", int'(pin), int'(exp_pin));
    h = int'(rhi);
    do_arm(h + 1, 3, 1'b1);
    chk("R9 accepted arm clears err", int'(err), 0);
    fire_check("R9 recovery", h + 1, 3, 1'b1);
  endtask

  task automatic t_train();
    int h = int'(rhi);
    do_arm(h + 1, 8, 1'b0);
    fire_check("R11 edge1", h + 1, 8, 1'b0);
    do_arm(h + 1, 16, 1'b1);
    fire_check("R11 edge2", h + 1, 16, 1'b1);
    do_arm(h + 1, 24, 1'b0);
    fire_check("R11 edge3", h + 1, 24, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_counter();
    t_future();
    t_clear();
    t_zero_low();
    t_current();
    t_busy_ignore();
    t_late();
    t_train();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule